// File: doc/BRIEF.md
# Charging-Delay Signature Diagnosis Controller

This block grades a header-switch segment that has already failed its stuck-open test. It works from a request carrying the index of the failing segment. It then repeats the charging test a fixed number of times on that segment, and each repetition watches a different observation point. On every repetition it asks the test sequencer to discharge the virtual supply and then wake the segment. From the moment the wake is reported, it counts system clock cycles until the selected observation cell reads logic-0. That count is the signature.

The counter has two guard bits above the width the fault-free maximum delay needs. A long faulty delay therefore pins the counter at all-ones and never wraps. Once every repetition is done, the segment index and the signatures form one record, and the block streams that record out one bit at a time.

The serial output uses a valid/ready handshake. `ser_valid` stays high for the whole record. A bit moves only in a cycle where `ser_valid` and `ser_ready` are both high. While `ser_ready` is low the block holds `ser_data` and keeps `ser_valid` high, so a slow consumer can stall it for as long as it needs. Requests and the sequencer handshakes are plain level/pulse pins.

Top module: `chg_sig_diag`

## Requirements
- R1: After reset, `diag_busy`, `seq_run_req` and `ser_valid` are 0 and `obs_sel` is 0.
- R2: A `diag_req` sampled while idle is taken on that edge. From the next cycle `diag_busy` and `seq_run_req` are 1 and `obs_sel` is 0.
- R3: Each repetition waits for `seq_dis_done` before it accepts `seq_wake_done`. `seq_run_req` stays high from the start of the repetition until the wake is accepted, and a wake pulse that arrives during the discharge wait is ignored.
- R4: The signature equals the number of rising edges, after the edge that accepts the wake, at which `obs_level` is sampled 1 before the first edge that samples it 0. If `obs_level` is 0 at the first edge, the signature is 0.
- R5: Signatures are SIG_W = clog2(MAX_CHG)+2 bits wide (6 by default) and saturate at all-ones. A repetition whose count reaches all-ones ends with the all-ones signature and does not wrap.
- R6: There are exactly RUNS repetitions (3 by default). Repetition k drives `obs_sel` = k mod NUM_OP, and the count restarts from 0 on every new request.
- R7: The record is SEG_W + SIG_W*RUNS bits (22 by default) and is sent MSB first. Its order is the segment index (4 bits), then signature 0, signature 1 and so on, each signature MSB first.
- R8: While `ser_valid` is 1 and `ser_ready` is 0, the next cycle keeps `ser_valid` at 1 and `ser_data` unchanged.
- R9: `diag_req` is ignored while `diag_busy` is 1, so the segment index in the record is the one captured at acceptance.
- R10: The cycle after the last bit is transferred, `ser_valid` and `diag_busy` are 0.
- R11: `obs_level` is ignored outside the counting phase. A low level during the discharge or wake wait does not end a repetition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that sets the signature resolution |
| rst_n | input | 1 | Active-low asynchronous reset |
| diag_req | input | 1 | Start a diagnosis for `diag_seg` (taken only when idle) |
| diag_seg | input | 4 | Index of the failing segment |
| diag_busy | output | 1 | A diagnosis or shift-out is in progress |
| seq_run_req | output | 1 | Asks the sequencer to discharge and then wake the segment |
| seq_dis_done | input | 1 | Pulse: discharge finished |
| seq_wake_done | input | 1 | Pulse: segment woken, application phase starts |
| obs_level | input | 1 | Level of the selected observation cell (0 = charged) |
| obs_sel | output | 3 | Observation point selected for the current repetition |
| ser_data | output | 1 | Serial record bit |
| ser_valid | output | 1 | `ser_data` holds a record bit |
| ser_ready | input | 1 | The consumer takes the bit on this edge |

## Verification
The bench drives delays of zero, one, mid-range values, the exact all-ones value and past all-ones, and compares each field of the streamed record with values it computes itself. A counter that was off by one, or that counted during the wake edge, would shift every signature. A counter that wrapped would return a small value where the record should hold 63.

Stray wake pulses and low observation levels are injected during the discharge wait. A design that skipped the discharge step, or sampled the cell outside the counting phase, would end the repetition early or record 0.

A second request arrives in mid-run, and `ser_ready` is toggled during shift-out. A design that accepted the second request would corrupt the segment index. One that shifted without the handshake would drop or repeat bits, which breaks the 22-bit record.

// File: rtl/chg_diag_pkg.sv
package chg_diag_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DISCH = 3'd1,
    ST_WAKE  = 3'd2,
    ST_COUNT = 3'd3,
    ST_SHIFT = 3'd4
  } diag_state_e;

  // Width of a signature: enough for the fault-free maximum plus two guard bits.
  function automatic int sig_width(input int max_cycles);
    return $clog2(max_cycles) + 2;
  endfunction
endpackage

// File: rtl/charge_counter.sv
module charge_counter #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] value,
  output logic         full
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              value <= '0;
    else if (clr)            value <= '0;
    else if (inc && !full)   value <= value + 1'b1;
  end

  assign full = (value == TOP);

  // R5: the count never wraps back down unless explicitly cleared
  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> value >= $past(value));
  // R5: once at all-ones it stays there until cleared
  p_sat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr) |=> full);
endmodule

// File: rtl/obs_rotator.sv
module obs_rotator #(
  parameter int NUM_OP = 8,
  localparam int OP_W = (NUM_OP > 1) ? $clog2(NUM_OP) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            step,
  output logic [OP_W-1:0] sel
);
  logic [OP_W-1:0] nxt;

  generate
    if ((1 << OP_W) == NUM_OP) begin : g_pow2
      assign nxt = sel + 1'b1;
    end else begin : g_mod
      localparam logic [OP_W-1:0] LAST = OP_W'(NUM_OP - 1);
      assign nxt = (sel == LAST) ? '0 : sel + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sel <= '0;
    else if (clr)   sel <= '0;
    else if (step)  sel <= nxt;
  end

  // R6: selection stays inside the implemented observation points
  p_op_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sel < OP_W'(NUM_OP) || NUM_OP == (1 << OP_W));
  // R6: every step moves to a different point
  p_op_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && NUM_OP > 1) |=> sel != $past(sel));
endmodule

// File: rtl/record_shifter.sv
module record_shifter #(
  parameter int SEG_W = 4,
  parameter int SIG_W = 6,
  parameter int RUNS  = 3,
  localparam int BODY_W = SIG_W * RUNS,
  localparam int REC_W  = SEG_W + BODY_W,
  localparam int CNT_W  = $clog2(REC_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_seg,
  input  logic [SEG_W-1:0] seg_in,
  input  logic             push_sig,
  input  logic [SIG_W-1:0] sig_in,
  input  logic             xfer,
  output logic             sdo,
  output logic             last_xfer
);
  logic [REC_W-1:0] rec;
  logic [BODY_W-1:0] body_next;
  logic [CNT_W-1:0]  sent;

  generate
    if (RUNS == 1) begin : g_single
      assign body_next = sig_in;
    end else begin : g_multi
      assign body_next = {rec[BODY_W-SIG_W-1:0], sig_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec  <= '0;
      sent <= '0;
    end else if (load_seg) begin
      rec  <= {seg_in, {BODY_W{1'b0}}};
      sent <= '0;
    end else if (push_sig) begin
      rec[BODY_W-1:0] <= body_next;
    end else if (xfer) begin
      rec  <= {rec[REC_W-2:0], 1'b0};
      sent <= sent + 1'b1;
    end
  end

  assign sdo       = rec[REC_W-1];
  assign last_xfer = xfer && (sent == CNT_W'(REC_W - 1));

  // R7: never more bits than the record length
  p_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sent <= CNT_W'(REC_W));
  // R7: the final bit closes the transfer count exactly
  p_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    last_xfer |=> sent == CNT_W'(REC_W));
endmodule

// File: rtl/chg_sig_diag.sv
module chg_sig_diag
  import chg_diag_pkg::*;
#(
  parameter int NUM_SEG = 16,
  parameter int NUM_OP  = 8,
  parameter int RUNS    = 3,
  parameter int MAX_CHG = 12,
  localparam int SEG_W  = $clog2(NUM_SEG),
  localparam int OP_W   = (NUM_OP > 1) ? $clog2(NUM_OP) : 1,
  localparam int SIG_W  = sig_width(MAX_CHG),
  localparam int IT_W   = $clog2(RUNS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            diag_req,
  input  logic [SEG_W-1:0] diag_seg,
  output logic            diag_busy,
  output logic            seq_run_req,
  input  logic            seq_dis_done,
  input  logic            seq_wake_done,
  input  logic            obs_level,
  output logic [OP_W-1:0] obs_sel,
  output logic            ser_data,
  output logic            ser_valid,
  input  logic            ser_ready
);
  diag_state_e state, state_n;
  logic [IT_W-1:0]  iter;
  logic [SIG_W-1:0] cnt_val;
  logic             cnt_full;
  logic             accept, wake_ok, meas_end, xfer, last_xfer, last_run;

  assign accept   = (state == ST_IDLE)  && diag_req;
  assign wake_ok  = (state == ST_WAKE)  && seq_wake_done;
  assign meas_end = (state == ST_COUNT) && (!obs_level || cnt_full);
  assign last_run = (iter == IT_W'(RUNS - 1));
  assign xfer     = (state == ST_SHIFT) && ser_ready;

  always_comb begin
    state_n = state;
    case (state)
      ST_IDLE:  if (diag_req)      state_n = ST_DISCH;
      ST_DISCH: if (seq_dis_done)  state_n = ST_WAKE;
      ST_WAKE:  if (seq_wake_done) state_n = ST_COUNT;
      ST_COUNT: if (meas_end)      state_n = last_run ? ST_SHIFT : ST_DISCH;
      ST_SHIFT: if (last_xfer)     state_n = ST_IDLE;
      default:                     state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      iter  <= '0;
    end else begin
      state <= state_n;
      if (accept)        iter <= '0;
      else if (meas_end) iter <= iter + 1'b1;
    end
  end

  charge_counter #(.W(SIG_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (wake_ok),
    .inc   ((state == ST_COUNT) && obs_level),
    .value (cnt_val),
    .full  (cnt_full)
  );

  obs_rotator #(.NUM_OP(NUM_OP)) u_rot (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .step  (meas_end),
    .sel   (obs_sel)
  );

  record_shifter #(.SEG_W(SEG_W), .SIG_W(SIG_W), .RUNS(RUNS)) u_rec (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_seg  (accept),
    .seg_in    (diag_seg),
    .push_sig  (meas_end),
    .sig_in    (cnt_val),
    .xfer      (xfer),
    .sdo       (ser_data),
    .last_xfer (last_xfer)
  );

  assign diag_busy   = (state != ST_IDLE);
  assign seq_run_req = (state == ST_DISCH) || (state == ST_WAKE);
  assign ser_valid   = (state == ST_SHIFT);

  // R3: request held until the wake is accepted
  p_run_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_run_req && !seq_wake_done) |=> seq_run_req);
  // R8: stalled output holds its bit
  p_sdo_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_valid && !ser_ready) |=> (ser_valid && $stable(ser_data)));
  // R9: a request while busy does not restart anything
  p_req_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (diag_busy && diag_req && !ser_valid) |=> diag_busy);
  // R10: output valid only while busy
  p_valid_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid |-> diag_busy);
  // R2: idle request starts a run on the next cycle
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!diag_busy && diag_req) |=> (seq_run_req && obs_sel == '0));
endmodule

// File: tb/chg_sig_diag_bench.sv
module chg_sig_diag_bench;
  localparam int SEG_W = 4;
  localparam int OP_W  = 3;
  localparam int SIG_W = 6;
  localparam int RUNS  = 3;
  localparam int REC_W = SEG_W + SIG_W * RUNS;
  localparam int SAT   = (1 << SIG_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic diag_req = 1'b0;
  logic [SEG_W-1:0] diag_seg = '0;
  logic diag_busy, seq_run_req, ser_data, ser_valid;
  logic seq_dis_done = 1'b0, seq_wake_done = 1'b0, obs_level = 1'b1, ser_ready = 1'b0;
  logic [OP_W-1:0] obs_sel;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  chg_sig_diag u_chg_sig_diag (
    .clk(clk), .rst_n(rst_n), .diag_req(diag_req), .diag_seg(diag_seg),
    .diag_busy(diag_busy), .seq_run_req(seq_run_req), .seq_dis_done(seq_dis_done),
    .seq_wake_done(seq_wake_done), .obs_level(obs_level), .obs_sel(obs_sel),
    .ser_data(ser_data), .ser_valid(ser_valid), .ser_ready(ser_ready)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected <150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int d);
    return (d > SAT) ? SAT : d;
  endfunction

  // One repetition as seen from the sequencer side.
  task automatic do_iter(input int d, input int exp_op, input bit poke, input logic [SEG_W-1:0] poke_seg);
    int guard = 0;
    while (!seq_run_req && guard < 200) begin @(negedge clk); guard++; end
    check(obs_sel == OP_W'(exp_op), "R6 obs_sel", obs_sel, exp_op);
    @(negedge clk);
    seq_wake_done = 1'b1;   // R3: stray wake during discharge must be ignored
    obs_level = 1'b0;       // R11: low level outside counting ignored
    if (poke) begin diag_req = 1'b1; diag_seg = poke_seg; end
    @(negedge clk);
    seq_wake_done = 1'b0; diag_req = 1'b0; seq_dis_done = 1'b1;
    @(negedge clk);
    seq_dis_done = 1'b0;
    check(seq_run_req == 1'b1, "R3 run_req held", seq_run_req, 1);
    seq_wake_done = 1'b1; obs_level = 1'b1;
    @(negedge clk);
    seq_wake_done = 1'b0;
    repeat (d) @(negedge clk);
    obs_level = 1'b0;
    @(negedge clk);
  endtask

  task automatic rx_check(input logic [REC_W-1:0] exp, input bit stall, input string sig_req);
    logic [REC_W-1:0] rec = '0;
    int got = 0;
    bit prev_stall = 0;
    logic prev_sdo = 1'b0;
    for (int i = 0; i < 400 && got < REC_W; i++) begin
      if (i > 0) @(negedge clk);
      if (prev_stall) check(ser_valid && ser_data == prev_sdo, "R8 stall hold", ser_data, prev_sdo);
      ser_ready = stall ? (i % 3 != 2) : 1'b1;
      if (ser_valid && ser_ready) begin rec = {rec[REC_W-2:0], ser_data}; got++; end
      prev_stall = ser_valid && !ser_ready;
      prev_sdo   = ser_data;
    end
    @(negedge clk);
    ser_ready = 1'b0;
    check(got == REC_W, "R7 record length", got, REC_W);
    check(!ser_valid && !diag_busy, "R10 idle after record", {ser_valid, diag_busy}, 0);
    check(rec[REC_W-1 -: SEG_W] == exp[REC_W-1 -: SEG_W], "R7/R9 segment field",
          rec[REC_W-1 -: SEG_W], exp[REC_W-1 -: SEG_W]);
    for (int k = 0; k < RUNS; k++) begin
      int hi = REC_W - SEG_W - 1 - k * SIG_W;
      check(rec[hi -: SIG_W] == exp[hi -: SIG_W], sig_req, rec[hi -: SIG_W], exp[hi -: SIG_W]);
    end
  endtask

  task automatic scenario(input logic [SEG_W-1:0] seg, input int d0, input int d1, input int d2,
                          input bit stall, input bit poke, input string sig_req);
    int d [RUNS];
    logic [REC_W-1:0] exp;
    d[0] = d0; d[1] = d1; d[2] = d2;
    exp = {seg, SIG_W'(sat(d0)), SIG_W'(sat(d1)), SIG_W'(sat(d2))};
    @(negedge clk);
    diag_req = 1'b1; diag_seg = seg;
    @(negedge clk);
    diag_req = 1'b0;
    check(diag_busy && seq_run_req && obs_sel == '0, "R2 accept", {diag_busy, seq_run_req}, 3);
    for (int k = 0; k < RUNS; k++) do_iter(d[k], k, poke && k == 1, seg ^ 4'h5);
    rx_check(exp, stall, sig_req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!diag_busy && !seq_run_req && !ser_valid && obs_sel == '0, "R1 reset",
          {diag_busy, seq_run_req, ser_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    scenario(4'd5,  5, 9, 2,  1'b0, 1'b0, "R4 signature basic");
    scenario(4'd15, 0, 1, 12, 1'b1, 1'b0, "R4 signature edges");
    scenario(4'd0,  70, 63, 62, 1'b0, 1'b0, "R5 saturation");
    scenario(4'd9,  3, 4, 7,  1'b1, 1'b1, "R9 busy request ignored");
    scenario(4'd6,  11, 8, 20, 1'b0, 1'b0, "R6 restart at point 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule